// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator with Register Bus

This block drives two pulse-width modulated outputs. A simple 32-bit register bus programs them. Each channel holds a period length (its range) and a count of high clocks per period (its data). A shared 16-bit control word gives each channel the following controls:

- a run bit;
- an output inversion bit;
- an idle level, driven while the channel is stopped;
- a selector between two waveform styles. The contiguous style gives one high pulse at the start of each period. The spread style distributes the high clocks as evenly as it can across the period, using an accumulator.

Every rising clock edge is one modulation clock. Several control bits belong to functions this block does not implement: serializer mode, repeat-last, use-FIFO and clear-FIFO. The block stores them and never acts on them. The status word and the DMA configuration word are plain read/write storage. A write to the FIFO port has no effect.

A channel picks up its range and data only at the start of a period, so software can change them while the channel runs without producing a broken period. The register bus reads combinationally. A write takes effect on the rising edge where `bus_sel` and `bus_wr` are both high.

Top module: `twin_pwm`

## Requirements
- R1: After reset every readable offset returns 0 and both outputs are 0.
- R2: These byte offsets are defined: 0x00 control, 0x04 status, 0x08 DMA config, 0x10 range of channel 0, 0x14 data of channel 0, 0x18 FIFO input, 0x20 range of channel 1, 0x24 data of channel 1. Status and DMA config store all 32 bits. Range and data store their low CNT_W bits, zero-extended on read. The FIFO offset and any other offset read 0.
- R3: Channel n owns control bits 8n+7..8n. From bit 0 upward these are: run, serializer mode, repeat-last, idle level, invert, use-FIFO, clear-FIFO, contiguous select. Bits 6 and 14 always read 0, and bits 31:16 read 0.
- R4: With run=1 and contiguous select=1, the channel is at position k (0 ≤ k < range) within its period. Its output is high when k < data. The level for position k appears on the output after the (k+2)th rising edge that follows the beginning of the enabling write's bus cycle.
- R5: With run=1 and contiguous select=0, the output at position k is high exactly when floor((k+1)·data/range) > floor(k·data/range). This gives exactly `data` high clocks per period.
- R6: A data value above range behaves as data = range, which gives a constant high level.
- R7: A range of 0 on a running channel holds its output at the idle level XOR invert.
- R8: A stopped channel outputs idle level XOR invert. When it is started again, it begins at period position 0.
- R9: Setting the invert bit inverts the waveform of R4 through R7.
- R10: Range and data written while a channel runs take effect at its next period start.
- R11: The two channels run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the modulation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 2 | Channel outputs, bit n for channel n |

## Verification
A period counter or accumulator that drifts shows at the output within one period, as a high clock in the wrong position. A latch of range or data at the wrong moment shows within the same period, as a count of high clocks that fits neither the old settings nor the new ones. The bench checks every modulation clock on both outputs against a per-position arithmetic formula. Its model tracks each bus write exactly, so any single misplaced cycle is caught.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;
   localparam int BUS_W     = 32;
   localparam int NUM_CH    = 2;
   localparam int CH_STRIDE = 8;

   localparam int OFF_CTRL  = 'h00;
   localparam int OFF_STAT  = 'h04;
   localparam int OFF_DMAC  = 'h08;
   localparam int OFF_RNG0  = 'h10;
   localparam int OFF_DAT0  = 'h14;
   localparam int OFF_CH_STEP = 'h10;

   localparam int B_RUN  = 0;
   localparam int B_IDLE = 3;
   localparam int B_INV  = 4;
   localparam int B_FCLR = 6;
   localparam int B_MS   = 7;

   typedef struct packed {
      logic run;
      logic ms_sel;
      logic invert;
      logic idle_lvl;
   } chan_drive_t;
endpackage

// File: rtl/twin_pwm_regs.sv
module twin_pwm_regs
   import twin_pwm_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           bus_sel,
   input  logic                           bus_wr,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic [BUS_W-1:0]               bus_wdata,
   output logic [BUS_W-1:0]               bus_rdata,
   output chan_drive_t [NUM_CH-1:0]       drv,
   output logic [NUM_CH-1:0][CNT_W-1:0]   rng,
   output logic [NUM_CH-1:0][CNT_W-1:0]   dat
);
   localparam int CTRL_W = NUM_CH * CH_STRIDE;
   localparam logic [CTRL_W-1:0] CTRL_KEEP =
      ~((CTRL_W'(1) << B_FCLR) | (CTRL_W'(1) << (B_FCLR + CH_STRIDE)));

   logic [CTRL_W-1:0] ctrl_q;
   logic [BUS_W-1:0]  stat_q, dmac_q;
   logic              wr_en;

   assign wr_en = bus_sel & bus_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         stat_q <= '0;
         dmac_q <= '0;
      end else if (wr_en) begin
         if (bus_addr == ADDR_W'(OFF_CTRL)) ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_KEEP;
         if (bus_addr == ADDR_W'(OFF_STAT)) stat_q <= bus_wdata;
         if (bus_addr == ADDR_W'(OFF_DMAC)) dmac_q <= bus_wdata;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int RNG_OFF = OFF_RNG0 + c * OFF_CH_STEP;
      localparam int DAT_OFF = OFF_DAT0 + c * OFF_CH_STEP;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rng[c] <= '0;
            dat[c] <= '0;
         end else if (wr_en) begin
            if (bus_addr == ADDR_W'(RNG_OFF)) rng[c] <= bus_wdata[CNT_W-1:0];
            if (bus_addr == ADDR_W'(DAT_OFF)) dat[c] <= bus_wdata[CNT_W-1:0];
         end
      end

      assign drv[c].run      = ctrl_q[c*CH_STRIDE + B_RUN];
      assign drv[c].ms_sel   = ctrl_q[c*CH_STRIDE + B_MS];
      assign drv[c].invert   = ctrl_q[c*CH_STRIDE + B_INV];
      assign drv[c].idle_lvl = ctrl_q[c*CH_STRIDE + B_IDLE];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = BUS_W'(ctrl_q);
      if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata = stat_q;
      if (bus_addr == ADDR_W'(OFF_DMAC)) bus_rdata = dmac_q;
      for (int c = 0; c < NUM_CH; c++) begin
         if (bus_addr == ADDR_W'(OFF_RNG0 + c * OFF_CH_STEP)) bus_rdata = BUS_W'(rng[c]);
         if (bus_addr == ADDR_W'(OFF_DAT0 + c * OFF_CH_STEP)) bus_rdata = BUS_W'(dat[c]);
      end
   end

   // R3: action bits and the upper half of the control word never read back
   assert_ctrl_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFF_CTRL)) |->
         (bus_rdata[B_FCLR] == 1'b0 && bus_rdata[B_FCLR+CH_STRIDE] == 1'b0 &&
          bus_rdata[BUS_W-1:CTRL_W] == '0));

   // R2: a control write lands in storage on the next cycle
   assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == ADDR_W'(OFF_CTRL)) |=>
         (ctrl_q == ($past(bus_wdata[CTRL_W-1:0]) & CTRL_KEEP)));
endmodule

// File: rtl/twin_pwm_chan.sv
module twin_pwm_chan
   import twin_pwm_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chan_drive_t      drv,
   input  logic [CNT_W-1:0] rng_in,
   input  logic [CNT_W-1:0] dat_in,
   output logic             pwm
);
   localparam int SUM_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt, acc, act_rng, act_dat;
   logic [CNT_W-1:0] r_use, d_use, d_eff, acc_base, cnt_nx, acc_nx;
   logic [SUM_W-1:0] sum;
   logic             boundary, level, idle;

   assign boundary = (cnt == '0);
   assign r_use    = boundary ? rng_in : act_rng;
   assign d_use    = boundary ? dat_in : act_dat;
   assign d_eff    = (d_use > r_use) ? r_use : d_use;
   assign acc_base = boundary ? '0 : acc;
   assign sum      = {1'b0, acc_base} + {1'b0, d_eff};
   assign idle     = drv.idle_lvl ^ drv.invert;

   always_comb begin
      level  = 1'b0;
      acc_nx = '0;
      cnt_nx = '0;
      if (r_use != '0) begin
         cnt_nx = (cnt == r_use - 1'b1) ? '0 : cnt + 1'b1;
         if (drv.ms_sel) begin
            level = (cnt < d_eff);
         end else begin
            level  = (sum >= {1'b0, r_use});
            acc_nx = level ? CNT_W'(sum - {1'b0, r_use}) : CNT_W'(sum);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         acc     <= '0;
         act_rng <= '0;
         act_dat <= '0;
         pwm     <= 1'b0;
      end else if (!drv.run) begin
         cnt     <= '0;
         acc     <= '0;
         act_rng <= rng_in;
         act_dat <= dat_in;
         pwm     <= idle;
      end else begin
         cnt <= cnt_nx;
         acc <= acc_nx;
         if (boundary) begin
            act_rng <= r_use;
            act_dat <= d_use;
         end
         pwm <= (r_use == '0) ? idle : (level ^ drv.invert);
      end
   end

   // R4: period position stays below the latched range
   assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_rng != '0) |-> (cnt < act_rng));

   // R5: accumulator residue stays below the latched range
   assert_acc_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == '0) || (acc < act_rng));

   // R8: a stopped channel drives its idle level
   assert_stopped_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!drv.run) |=> (pwm == $past(drv.idle_lvl ^ drv.invert)));

   // R7: zero range at a period start holds the idle level
   assert_zero_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (drv.run && boundary && rng_in == '0) |=> (pwm == $past(idle)));

   // R10: latched settings hold inside a period
   assert_mid_period_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (drv.run && !boundary) |=> (act_dat == $past(act_dat) && act_rng == $past(act_rng)));
endmodule

// File: rtl/twin_pwm.sv
module twin_pwm
   import twin_pwm_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [1:0]        pwm_out
);
   localparam int TOP_OFF = OFF_DAT0 + (NUM_CH - 1) * OFF_CH_STEP;

   if (CNT_W < 1 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("twin_pwm: CNT_W must lie in 1..32");
   end
   if ((1 << ADDR_W) <= TOP_OFF) begin : g_bad_addr
      $error("twin_pwm: ADDR_W too small for the register map");
   end

   chan_drive_t [NUM_CH-1:0]       drv;
   logic [NUM_CH-1:0][CNT_W-1:0]   rng, dat;

   twin_pwm_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .drv       (drv),
      .rng       (rng),
      .dat       (dat)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      twin_pwm_chan #(.CNT_W(CNT_W)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .drv    (drv[c]),
         .rng_in (rng[c]),
         .dat_in (dat[c]),
         .pwm    (pwm_out[c])
      );
   end
endmodule

// File: tb/twin_pwm_tb_top.sv
module twin_pwm_tb_top;
   localparam int CW = 4;
   localparam logic [CW-1:0] CMASK = '1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  pwm_out;

   int nvec = 0;
   int nfail = 0;

   logic [15:0] m_ctl;
   int          m_rng [2];
   int          m_dat [2];
   int          m_pos [2];
   int          m_cr  [2];
   int          m_cd  [2];
   logic        m_exp [2];
   string       m_tag [2];

   always #5 clk = ~clk;

   twin_pwm #(.ADDR_W(8), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_out(pwm_out)
   );

   initial begin
      #(2_000_000);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   task automatic step_model();
      for (int c = 0; c < 2; c++) begin
         logic [7:0] b;
         int r, d;
         b = m_ctl[8*c +: 8];
         if (!b[0]) begin
            m_pos[c] = 0;
            m_exp[c] = b[3] ^ b[4];
            m_tag[c] = "R8";
         end else begin
            if (m_pos[c] == 0) begin
               m_cr[c] = m_rng[c];
               m_cd[c] = m_dat[c];
            end
            r = m_cr[c];
            d = m_cd[c];
            if (r == 0) begin
               m_exp[c] = b[3] ^ b[4];
               m_tag[c] = "R7";
               m_pos[c] = 0;
            end else begin
               m_tag[c] = (d > r) ? "R6" : (b[7] ? "R4" : "R5");
               if (d > r) d = r;
               if (b[7]) m_exp[c] = (m_pos[c] < d);
               else m_exp[c] = (((m_pos[c] + 1) * d) / r) != ((m_pos[c] * d) / r);
               m_exp[c] = m_exp[c] ^ b[4];
               m_pos[c] = (m_pos[c] + 1 == r) ? 0 : m_pos[c] + 1;
            end
         end
      end
   endtask

   // called at a negedge; one posedge passes, which the model also steps
   task automatic set_reg(input logic [7:0] a, input logic [31:0] v);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      step_model();
      case (a)
         8'h00: m_ctl = v[15:0] & 16'hBFBF;
         8'h10: m_rng[0] = int'(v[CW-1:0]);
         8'h14: m_dat[0] = int'(v[CW-1:0]);
         8'h20: m_rng[1] = int'(v[CW-1:0]);
         8'h24: m_dat[1] = int'(v[CW-1:0]);
         default: ;
      endcase
   endtask

   task automatic check_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
      bus_addr = a;
      #1;
      nvec++;
      if (bus_rdata !== exp) begin
         nfail++;
         $display("FAIL %s read 0x%02h: got 0x%08h exp 0x%08h", req, a, bus_rdata, exp);
      end
   endtask

   task automatic run(input int n, input string ctx);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         step_model();
         for (int c = 0; c < 2; c++) begin
            nvec++;
            if (pwm_out[c] !== m_exp[c]) begin
               nfail++;
               $display("FAIL %s/%s ch%0d: got %b exp %b", ctx, m_tag[c], c, pwm_out[c], m_exp[c]);
            end
         end
      end
   endtask

   initial begin
      m_ctl = '0;
      for (int c = 0; c < 2; c++) begin
         m_rng[c] = 0; m_dat[c] = 0; m_pos[c] = 0; m_cr[c] = 0; m_cd[c] = 0;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int a = 0; a <= 'h24; a += 4) check_rd(8'(a), 32'h0, "R1");
      nvec++;
      if (pwm_out !== 2'b00) begin
         nfail++;
         $display("FAIL R1 outputs: got %b exp 00", pwm_out);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R2: storage and zero-extension
      set_reg(8'h04, 32'hA5A5_1234); check_rd(8'h04, 32'hA5A5_1234, "R2");
      set_reg(8'h08, 32'h0F0F_F0F0); check_rd(8'h08, 32'h0F0F_F0F0, "R2");
      set_reg(8'h10, 32'hFFFF_FFF7); check_rd(8'h10, 32'h7, "R2");
      set_reg(8'h24, 32'h0000_0035); check_rd(8'h24, 32'h5, "R2");
      set_reg(8'h18, 32'h1234_5678); check_rd(8'h18, 32'h0, "R2");
      set_reg(8'h30, 32'hFFFF_FFFF); check_rd(8'h30, 32'h0, "R2");
      check_rd(8'h0C, 32'h0, "R2");
      check_rd(8'h04, 32'hA5A5_1234, "R2");

      // R3: control bit packing
      set_reg(8'h00, 32'hFFFF_FFFF); check_rd(8'h00, 32'h0000_BFBF, "R3");
      set_reg(8'h00, 32'h0000_2626); check_rd(8'h00, 32'h0000_2626, "R3");
      set_reg(8'h00, 32'h0);         check_rd(8'h00, 32'h0, "R3");

      // R8: idle levels while stopped
      set_reg(8'h00, 32'h0000_0008); run(3, "R8");
      set_reg(8'h00, 32'h0000_1800); run(3, "R8");
      set_reg(8'h00, 32'h0000_1018); run(3, "R8");

      // R4 and R8: run, stop, restart from period start
      set_reg(8'h10, 32'd5); set_reg(8'h14, 32'd2);
      set_reg(8'h00, 32'h0000_0081); run(3, "R4");
      set_reg(8'h00, 32'h0000_0000); run(2, "R8");
      set_reg(8'h00, 32'h0000_0081); run(7, "R8");

      // R9: inverted contiguous and spread waveforms
      set_reg(8'h10, 32'd4); set_reg(8'h14, 32'd1);
      set_reg(8'h00, 32'h0000_0091); run(9, "R9");
      set_reg(8'h10, 32'd7); set_reg(8'h14, 32'd3);
      set_reg(8'h00, 32'h0000_0011); run(15, "R9");

      // R10: mid-period updates
      set_reg(8'h00, 32'h0); set_reg(8'h10, 32'd5); set_reg(8'h14, 32'd2);
      set_reg(8'h00, 32'h0000_0081); run(3, "R10");
      set_reg(8'h14, 32'd4); run(4, "R10");
      set_reg(8'h10, 32'd3); run(10, "R10");
      set_reg(8'h14, 32'd1); set_reg(8'h00, 32'h0000_0001); run(12, "R10");

      // R11 sweep: both channels, both styles, covering R4..R7
      for (int m = 0; m < 2; m++) begin
         for (int r = 0; r < 7; r++) begin
            for (int d = 0; d < 9; d++) begin
               logic [7:0] b0, b1;
               b0 = (m == 1) ? 8'h81 : 8'h01;
               b1 = (m == 1) ? 8'h01 : 8'h81;
               if (((r + d) & 1) == 1) b0 = b0 | 8'h10;
               if ((d & 2) != 0) b1 = b1 | 8'h18;
               set_reg(8'h10, 32'(r));
               set_reg(8'h14, 32'(d));
               set_reg(8'h20, 32'((r + 3) % 7));
               set_reg(8'h24, 32'((d * 3) % 10));
               set_reg(8'h00, {16'h0, b1, b0});
               run(2 * 7 + 3, "R11");
            end
         end
      end

      // R6: large data in both styles
      set_reg(8'h10, 32'd6); set_reg(8'h14, {28'h0, CMASK});
      set_reg(8'h00, 32'h0000_0001); run(12, "R6");
      set_reg(8'h00, 32'h0000_0081); run(12, "R6");

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule